// File: doc/BRIEF.md
# Machine-Mode Source Selection Controller

This block decides which source feeds each of the bunch-clock and orbit multiplexers on a timing distribution board. It produces one 9-bit selection vector covering the three single-ring bunch-clock selects, the main bunch-clock select, the two single-ring orbit selects and the main orbit select.

In manual mode the vector is assembled directly from the manual select inputs. In the three automatic modes, the current 8-bit machine mode is looked up in a 32-bit mask to decide whether the accelerator is in a run or a no-run phase. A no-run phase applies one shared no-run configuration. A run phase applies the run configuration that belongs to the active automatic mode. The decision is held in a small state register, and the selection vector is registered behind that state, so the multiplexer controls never glitch.

Top module: `src_select_ctrl`

## Requirements
- R1: While `rst` is high and after reset, `state_o` is 0 (manual) and `sel_vec` is 0.
- R2: `work_mode` 0 gives state 0 (manual), and `sel_vec` is assembled from the manual selects: bit0 `man_bc1`, bit1 `man_bc2`, bit2 `man_bcref`, bits4:3 `man_main_bc`, bit5 `man_orb1`, bit6 `man_orb2`, bits8:7 `man_main_orb`.
- R3: Any `work_mode` value from 4 to 15 behaves as manual (state 0).
- R4: With `work_mode` 1 to 3 and `mach_mode` below 32, bit `mach_mode` of `run_mask` selects run when it is 1 and no-run when it is 0.
- R5: A `mach_mode` of 32 or above is always no-run, whatever the mask holds.
- R6: In no-run (state 1), `sel_vec` equals `cfg_norun` for every automatic mode.
- R7: In run, the state is 2, 3 or 4 for automatic modes 1, 2 or 3, and `sel_vec` equals `cfg_run1`, `cfg_run2` or `cfg_run3` respectively.
- R8: `state_o` takes its new value one clock after the inputs change, and `sel_vec` follows one clock after `state_o`; in between `sel_vec` keeps the old selection.
- R9: A change of the configuration used by the current state reaches `sel_vec` one clock later, with no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| work_mode | input | 4 | 0 manual, 1..3 automatic mode, others manual |
| mach_mode | input | 8 | Current machine mode |
| run_mask | input | 32 | One run flag per machine mode |
| cfg_norun | input | 9 | Shared no-run selection |
| cfg_run1 | input | 9 | Run selection, automatic mode 1 |
| cfg_run2 | input | 9 | Run selection, automatic mode 2 |
| cfg_run3 | input | 9 | Run selection, automatic mode 3 |
| man_bc1 | input | 1 | Manual ring-1 bunch-clock select |
| man_bc2 | input | 1 | Manual ring-2 bunch-clock select |
| man_bcref | input | 1 | Manual reference bunch-clock select |
| man_main_bc | input | 2 | Manual main bunch-clock select |
| man_orb1 | input | 1 | Manual ring-1 orbit select |
| man_orb2 | input | 1 | Manual ring-2 orbit select |
| man_main_orb | input | 2 | Manual main orbit select |
| sel_vec | output | 9 | Registered selection vector |
| state_o | output | 3 | Current state code |

## Verification
A wrong state shows at `state_o` one clock after the offending input and, one clock later still, as a `sel_vec` drawn from the wrong configuration, typically the no-run set applied during a run or the run set of a different automatic mode. A misread mask bit or a missed out-of-range machine mode shows the same way within two clocks. Random configurations with distinct values in all four sets make any wrong pick visible, and directed steps pin the two-stage latency.

// File: rtl/src_sel_pkg.sv
package src_sel_pkg;

    localparam int MODE_W   = 8;
    localparam int MASK_W   = 32;
    localparam int WMODE_W  = 4;
    localparam int NUM_AUTO = 3;
    localparam int SEL_W    = 9;

    typedef struct packed {
        logic [1:0] main_orb;
        logic       orb2;
        logic       orb1;
        logic [1:0] main_bc;
        logic       bcref;
        logic       bc2;
        logic       bc1;
    } sel_t;

    typedef enum logic [2:0] {
        ST_MANUAL = 3'd0,
        ST_NORUN  = 3'd1,
        ST_RUN1   = 3'd2,
        ST_RUN2   = 3'd3,
        ST_RUN3   = 3'd4
    } state_e;

    function automatic logic is_auto(input logic [WMODE_W-1:0] wm);
        return (wm >= WMODE_W'(1)) && (wm <= WMODE_W'(NUM_AUTO));
    endfunction

    function automatic state_e pick_state(input logic [WMODE_W-1:0] wm,
                                          input logic run);
        state_e s;
        if (!is_auto(wm))      s = ST_MANUAL;
        else if (!run)         s = ST_NORUN;
        else begin
            case (wm[1:0])
                2'd1:    s = ST_RUN1;
                2'd2:    s = ST_RUN2;
                default: s = ST_RUN3;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/run_classifier.sv
module run_classifier
    import src_sel_pkg::*;
#(
    parameter int M_W = MODE_W,
    parameter int K_W = MASK_W
) (
    input  logic [M_W-1:0] mach_mode,
    input  logic [K_W-1:0] run_mask,
    output logic           is_run
);
    localparam int IDX_W = $clog2(K_W);

    logic out_of_range;

    generate
        if (M_W > IDX_W) begin : g_range
            assign out_of_range = |mach_mode[M_W-1:IDX_W];
        end else begin : g_norange
            assign out_of_range = 1'b0;
        end
    endgenerate

    assign is_run = out_of_range ? 1'b0 : run_mask[mach_mode[IDX_W-1:0]];

    // R5: values past the mask never read as run
    always_comb begin
        if (out_of_range)
            p_high_mode_norun_r5: assert (is_run == 1'b0);
    end

endmodule

// File: rtl/sel_state_reg.sv
module sel_state_reg
    import src_sel_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [WMODE_W-1:0] work_mode,
    input  logic               is_run,
    output state_e             state_q
);

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_MANUAL;
        else     state_q <= pick_state(work_mode, is_run);
    end

    p_state_legal_r7: assert property (@(posedge clk) disable iff (rst)
        state_q inside {ST_MANUAL, ST_NORUN, ST_RUN1, ST_RUN2, ST_RUN3});

    p_manual_mode_r3: assert property (@(posedge clk) disable iff (rst)
        !is_auto(work_mode) |=> state_q == ST_MANUAL);

    p_norun_r4: assert property (@(posedge clk) disable iff (rst)
        (is_auto(work_mode) && !is_run) |=> state_q == ST_NORUN);

    p_run_r4: assert property (@(posedge clk) disable iff (rst)
        (is_auto(work_mode) && is_run) |=>
            (state_q != ST_MANUAL && state_q != ST_NORUN));

endmodule

// File: rtl/sel_out_reg.sv
module sel_out_reg
    import src_sel_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  state_e state_q,
    input  sel_t   manual_sel,
    input  sel_t   norun_sel,
    input  sel_t   run_sel [NUM_AUTO],
    output sel_t   sel_q
);

    sel_t chosen;

    always_comb begin
        case (state_q)
            ST_MANUAL: chosen = manual_sel;
            ST_NORUN:  chosen = norun_sel;
            ST_RUN1:   chosen = run_sel[0];
            ST_RUN2:   chosen = run_sel[1];
            ST_RUN3:   chosen = run_sel[2];
            default:   chosen = manual_sel;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) sel_q <= '0;
        else     sel_q <= chosen;
    end

    // R8: a state held with a held source keeps the output quiet
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
        ($stable(state_q) && $stable(chosen)) |=> $stable(sel_q));

    // R6: no-run state hands over the shared set one clock later
    p_norun_cfg_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_NORUN) |=> sel_q == $past(norun_sel));

endmodule

// File: rtl/src_select_ctrl.sv
module src_select_ctrl
    import src_sel_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [WMODE_W-1:0] work_mode,
    input  logic [MODE_W-1:0]  mach_mode,
    input  logic [MASK_W-1:0]  run_mask,
    input  logic [SEL_W-1:0]   cfg_norun,
    input  logic [SEL_W-1:0]   cfg_run1,
    input  logic [SEL_W-1:0]   cfg_run2,
    input  logic [SEL_W-1:0]   cfg_run3,
    input  logic               man_bc1,
    input  logic               man_bc2,
    input  logic               man_bcref,
    input  logic [1:0]         man_main_bc,
    input  logic               man_orb1,
    input  logic               man_orb2,
    input  logic [1:0]         man_main_orb,
    output logic [SEL_W-1:0]   sel_vec,
    output logic [2:0]         state_o
);

    logic   is_run;
    state_e state_q;
    sel_t   manual_sel;
    sel_t   run_sel [NUM_AUTO];
    sel_t   sel_q;

    always_comb begin
        manual_sel.bc1      = man_bc1;
        manual_sel.bc2      = man_bc2;
        manual_sel.bcref    = man_bcref;
        manual_sel.main_bc  = man_main_bc;
        manual_sel.orb1     = man_orb1;
        manual_sel.orb2     = man_orb2;
        manual_sel.main_orb = man_main_orb;
    end

    assign run_sel[0] = sel_t'(cfg_run1);
    assign run_sel[1] = sel_t'(cfg_run2);
    assign run_sel[2] = sel_t'(cfg_run3);

    run_classifier #(.M_W(MODE_W), .K_W(MASK_W)) u_cls (
        .mach_mode (mach_mode),
        .run_mask  (run_mask),
        .is_run    (is_run)
    );

    sel_state_reg u_st (
        .clk       (clk),
        .rst       (rst),
        .work_mode (work_mode),
        .is_run    (is_run),
        .state_q   (state_q)
    );

    sel_out_reg u_out (
        .clk        (clk),
        .rst        (rst),
        .state_q    (state_q),
        .manual_sel (manual_sel),
        .norun_sel  (sel_t'(cfg_norun)),
        .run_sel    (run_sel),
        .sel_q      (sel_q)
    );

    assign sel_vec = sel_q;
    assign state_o = state_q;

    // R2: manual state hands the manual selects to the output one clock later
    p_manual_out_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MANUAL) |=> sel_vec == $past({man_main_orb, man_orb2,
            man_orb1, man_main_bc, man_bcref, man_bc2, man_bc1}));

    // R7: run state of mode 2 hands over its own set
    p_run2_out_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN2) |=> sel_vec == $past(cfg_run2));

endmodule

// File: tb/tb_src_select_ctrl.sv
`timescale 1ns/1ps
module tb_src_select_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  work_mode = '0;
    logic [7:0]  mach_mode = '0;
    logic [31:0] run_mask = '0;
    logic [8:0]  cfg_norun = '0, cfg_run1 = '0, cfg_run2 = '0, cfg_run3 = '0;
    logic        man_bc1 = 0, man_bc2 = 0, man_bcref = 0, man_orb1 = 0, man_orb2 = 0;
    logic [1:0]  man_main_bc = '0, man_main_orb = '0;
    logic [8:0]  sel_vec;
    logic [2:0]  state_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    src_select_ctrl dut (
        .clk(clk), .rst(rst), .work_mode(work_mode), .mach_mode(mach_mode),
        .run_mask(run_mask), .cfg_norun(cfg_norun), .cfg_run1(cfg_run1),
        .cfg_run2(cfg_run2), .cfg_run3(cfg_run3), .man_bc1(man_bc1),
        .man_bc2(man_bc2), .man_bcref(man_bcref), .man_main_bc(man_main_bc),
        .man_orb1(man_orb1), .man_orb2(man_orb2), .man_main_orb(man_main_orb),
        .sel_vec(sel_vec), .state_o(state_o)
    );

    function automatic logic [8:0] manual_vec();
        return {man_main_orb, man_orb2, man_orb1, man_main_bc, man_bcref, man_bc2, man_bc1};
    endfunction

    function automatic logic [2:0] exp_state();
        logic run;
        if (work_mode == 0 || work_mode > 3) return 3'd0;
        run = (mach_mode < 32) ? run_mask[mach_mode[4:0]] : 1'b0;
        if (!run) return 3'd1;
        return 3'(work_mode + 1);
    endfunction

    function automatic logic [8:0] exp_sel(input logic [2:0] st);
        case (st)
            3'd0: return manual_vec();
            3'd1: return cfg_norun;
            3'd2: return cfg_run1;
            3'd3: return cfg_run2;
            default: return cfg_run3;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] st);
        case (st)
            3'd0: return (work_mode == 0) ? "R2" : "R3";
            3'd1: return (mach_mode >= 32) ? "R5" : "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic settle_and_check();
        logic [2:0] es;
        repeat (3) @(posedge clk);
        @(negedge clk);
        es = exp_state();
        check({tag_of(es), "/R4 state"}, {6'd0, state_o}, {6'd0, es});
        check({tag_of(es), " sel"}, sel_vec, exp_sel(es));
    endtask

    task automatic rand_inputs();
        work_mode = 4'($urandom_range(0, 15));
        if ($urandom_range(0, 3) != 0) work_mode = 4'($urandom_range(1, 3));
        mach_mode = ($urandom_range(0, 5) == 0) ? 8'($urandom_range(32, 255))
                                                : 8'($urandom_range(0, 31));
        run_mask  = $urandom;
        cfg_norun = 9'($urandom); cfg_run1 = 9'($urandom);
        cfg_run2  = 9'($urandom); cfg_run3 = 9'($urandom);
        {man_main_orb, man_orb2, man_orb1, man_main_bc, man_bcref, man_bc2, man_bc1} = 9'($urandom);
    endtask

    initial begin
        void'($urandom(32'd12345));
        // R1: reset state
        cfg_norun = 9'h1FF; man_bc1 = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 state in reset", {6'd0, state_o}, 9'd0);
        check("R1 sel in reset", sel_vec, 9'd0);
        rst = 0;

        // R2: manual layout
        work_mode = 0; man_bc1 = 1; man_bc2 = 0; man_bcref = 1; man_main_bc = 2'b10;
        man_orb1 = 0; man_orb2 = 1; man_main_orb = 2'b01;
        settle_and_check();
        check("R2 layout", sel_vec, 9'b01_1_0_10_1_0_1);

        // R3: out-of-range working mode
        work_mode = 4'd9; run_mask = '1; mach_mode = 8'd3;
        settle_and_check();
        check("R3 mode 9 manual", {6'd0, state_o}, 9'd0);

        // R5: high machine mode with all-ones mask
        work_mode = 4'd2; mach_mode = 8'd40; cfg_norun = 9'h0C3;
        settle_and_check();
        check("R5 high mode norun", sel_vec, 9'h0C3);

        // R4: top mask bit
        mach_mode = 8'd31; run_mask = 32'h8000_0000; cfg_run2 = 9'h13C;
        settle_and_check();
        check("R4 bit31 run", {6'd0, state_o}, 9'd3);

        // R6: same no-run set in mode 3
        work_mode = 4'd3; mach_mode = 8'd0;
        settle_and_check();
        check("R6 shared norun", sel_vec, 9'h0C3);

        // R8: latency from manual into run of mode 1
        work_mode = 0; run_mask = 32'h0000_0020; mach_mode = 8'd5;
        cfg_run1 = 9'h1A5;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R8 manual baseline", sel_vec, manual_vec());
        work_mode = 4'd1;
        @(posedge clk); @(negedge clk);
        check("R8 state after one clock", {6'd0, state_o}, 9'd2);
        check("R8 sel still old", sel_vec, manual_vec());
        @(posedge clk); @(negedge clk);
        check("R8 sel after two clocks", sel_vec, 9'h1A5);

        // R9: config change inside steady run
        cfg_run1 = 9'h05A;
        @(posedge clk); @(negedge clk);
        check("R9 cfg follows in one clock", sel_vec, 9'h05A);
        check("R9 state unchanged", {6'd0, state_o}, 9'd2);

        // random mix
        for (int i = 0; i < 80; i++) begin
            rand_inputs();
            settle_and_check();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule